// File: doc/BRIEF.md
# Status register write-protect controller

This block owns the protection state of a small serial nonvolatile memory and decides, byte by byte, whether a write may commit. It holds a status byte made of a write-enable latch, two block-protect bits and a protect-pin enable bit. It answers two questions continuously. May a memory byte be written at the address now presented? May the status byte be written now? The serial command decoder beside it pulses the latch set and clear strobes, pulses the status-write strobe together with the incoming byte, and presents the target address of every data byte of a streaming write.

The write-enable latch is a two-state machine with states `WEL_OFF` and `WEL_ON`. The transition `ARM` (from `WEL_OFF` to `WEL_ON`) is taken on a set strobe without a clear strobe. The transition `DISARM` (from `WEL_ON` to `WEL_OFF`) is taken on a clear strobe. The interface reset forces `WEL_OFF`. The protect-enable and block-protect bits are not touched by that reset: they model nonvolatile bits and take a parameter value at power-up. The grants are combinational. A strobe sampled at a clock edge is visible from the following cycle.

Top module: `wp_ctrl`

## Requirements
- R1: `sr_rdata` is laid out as bit 7 protect-enable, bit 3 BP1, bit 2 BP0 and bit 1 write-enable latch. Bits 6:4 and bit 0 always read 0.
- R2: After reset the latch reads 0. After an edge with `wel_set` high and `wel_clr` low it reads 1. After an edge with `wel_clr` high it reads 0, and this holds even when `wel_set` is also high.
- R3: A status write never changes the latch bit, whatever value bit 1 of `sr_wdata` carries.
- R4: With BP1:BP0 = 00 no address is protected. With 01 the range 0x1800–0x1FFF is protected. With 10 the range 0x1000–0x1FFF is protected. With 11 every address is protected. `mem_wr_ok` is 1 only when the latch is 1 and `mem_addr` lies outside the protected range.
- R5: `wp_n` has no effect on `mem_wr_ok`.
- R6: `sr_wr_ok` is 1 only when the latch is 1 and it is not the case that protect-enable is 1 while `wp_n` is 0. A status write made while `sr_wr_ok` is 0 leaves the status byte unchanged.
- R7: While protect-enable is 0, `wp_n` has no effect on `sr_wr_ok`.
- R8: Reset clears the latch but keeps protect-enable, BP1 and BP0.
- R9: A granted status write loads bits 7, 3 and 2 of `sr_wdata` into protect-enable, BP1 and BP0 at the next edge. All other bits are discarded.
- R10: When a status write and a latch clear fall on the same edge, the write is judged against the latch value before that edge. The write commits and the latch ends at 0.
- R11: The memory grant follows the address presented in each cycle. A streaming write that steps into a protected range loses its grant from the first protected address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low interface reset; clears only the latch |
| wel_set | input | 1 | Strobe that sets the write-enable latch |
| wel_clr | input | 1 | Strobe that clears the write-enable latch |
| sr_wr | input | 1 | Status write strobe |
| sr_wdata | input | 8 | Byte offered by a status write |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| mem_addr | input | 13 | Target address of the pending memory byte write |
| sr_rdata | output | 8 | Current status byte |
| mem_wr_ok | output | 1 | Memory byte write is granted at `mem_addr` |
| sr_wr_ok | output | 1 | Status write is granted now |

## Verification
The status write and the latch clear can land on the same edge, because the decoder ends every status write by dropping the latch. The bench provokes this by pulsing `sr_wr` together with `wel_clr` while the latch is set. It judges the result by reading back a status byte that carries the new protect bits and a cleared latch. It also drives set and clear together and expects the latch to read 0.

// File: rtl/wp_ctrl_pkg.sv
package wp_ctrl_pkg;
    localparam int SR_W      = 8;
    localparam int BIT_WPEN  = 7;
    localparam int BIT_BP1   = 3;
    localparam int BIT_BP0   = 2;
    localparam int BIT_WEL   = 1;

    typedef enum logic {
        WEL_OFF = 1'b0,
        WEL_ON  = 1'b1
    } wel_state_t;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } prot_bits_t;
endpackage

// File: rtl/wp_wel_fsm.sv
module wp_wel_fsm
    import wp_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    wel_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WEL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WEL_OFF: if (set_i && !clr_i) state_d = WEL_ON;
            WEL_ON:  if (clr_i)           state_d = WEL_OFF;
            default: state_d = WEL_OFF;
        endcase
    end

    always_comb begin
        wel_o = (state_q == WEL_ON);
    end
endmodule

// File: rtl/wp_prot_regs.sv
module wp_prot_regs
    import wp_ctrl_pkg::*;
#(
    parameter logic [2:0] PROT_INIT = 3'b000
) (
    input  logic            clk,
    input  logic            load_i,
    input  logic [SR_W-1:0] data_i,
    output prot_bits_t      prot_o
);
    prot_bits_t prot_q = prot_bits_t'(PROT_INIT);

    always_ff @(posedge clk) begin
        if (load_i) begin
            prot_q.wpen <= data_i[BIT_WPEN];
            prot_q.bp   <= {data_i[BIT_BP1], data_i[BIT_BP0]};
        end
    end

    assign prot_o = prot_q;
endmodule

// File: rtl/wp_range_chk.sv
module wp_range_chk #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    always_comb begin
        unique case (bp_i)
            2'b00: hit_o = 1'b0;
            2'b01: hit_o = addr_i[TOP] & addr_i[NXT];
            2'b10: hit_o = addr_i[TOP];
            2'b11: hit_o = 1'b1;
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
    import wp_ctrl_pkg::*;
#(
    parameter int         ADDR_W    = 13,
    parameter logic [2:0] PROT_INIT = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              sr_wr,
    input  logic [SR_W-1:0]   sr_wdata,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [SR_W-1:0]   sr_rdata,
    output logic              mem_wr_ok,
    output logic              sr_wr_ok
);
    logic       wel;
    logic       hit;
    logic       sr_load;
    prot_bits_t prot;

    wp_wel_fsm u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wel_set),
        .clr_i (wel_clr),
        .wel_o (wel)
    );

    assign sr_load = sr_wr && sr_wr_ok;

    wp_prot_regs #(.PROT_INIT(PROT_INIT)) u_prot (
        .clk    (clk),
        .load_i (sr_load),
        .data_i (sr_wdata),
        .prot_o (prot)
    );

    wp_range_chk #(.ADDR_W(ADDR_W)) u_range (
        .bp_i   (prot.bp),
        .addr_i (mem_addr),
        .hit_o  (hit)
    );

    always_comb begin
        sr_rdata           = '0;
        sr_rdata[BIT_WPEN] = prot.wpen;
        sr_rdata[BIT_BP1]  = prot.bp[1];
        sr_rdata[BIT_BP0]  = prot.bp[0];
        sr_rdata[BIT_WEL]  = wel;
        mem_wr_ok          = wel && !hit;
        sr_wr_ok           = wel && !(prot.wpen && !wp_n);
    end
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wel_set,
    input logic              wel_clr,
    input logic              sr_wr,
    input logic [7:0]        sr_wdata,
    input logic              wp_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        sr_rdata,
    input logic              mem_wr_ok,
    input logic              sr_wr_ok
);
    assert_fixed_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rdata[6:4] == 3'b000) && (sr_rdata[0] == 1'b0));

    assert_wel_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !sr_rdata[1]);

    assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set && !wel_clr) |=> sr_rdata[1]);

    assert_sr_keeps_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && !wel_set && !wel_clr) |=> $stable(sr_rdata[1]));

    assert_mem_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_ok |-> (sr_rdata[1] && (sr_rdata[3:2] != 2'b11)));

    assert_sr_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && !sr_wr_ok) |=> $stable({sr_rdata[7], sr_rdata[3:2]}));

    assert_pin_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_rdata[7] |-> (sr_wr_ok == sr_rdata[1]));

    assert_sr_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && sr_wr_ok) |=> ({sr_rdata[7], sr_rdata[3:2]} ==
                                 $past({sr_wdata[7], sr_wdata[3:2]})));
endmodule

bind wp_ctrl wp_ctrl_chk #(.ADDR_W(ADDR_W)) u_wp_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wel_set   (wel_set),
    .wel_clr   (wel_clr),
    .sr_wr     (sr_wr),
    .sr_wdata  (sr_wdata),
    .wp_n      (wp_n),
    .mem_addr  (mem_addr),
    .sr_rdata  (sr_rdata),
    .mem_wr_ok (mem_wr_ok),
    .sr_wr_ok  (sr_wr_ok)
);

// File: tb/tb_wp_ctrl.sv
module tb_wp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wel_set = 1'b0;
    logic        wel_clr = 1'b0;
    logic        sr_wr = 1'b0;
    logic [7:0]  sr_wdata = 8'h00;
    logic        wp_n = 1'b1;
    logic [12:0] mem_addr = 13'h0000;
    logic [7:0]  sr_rdata;
    logic        mem_wr_ok;
    logic        sr_wr_ok;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    wp_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr),
        .sr_wr     (sr_wr),
        .sr_wdata  (sr_wdata),
        .wp_n      (wp_n),
        .mem_addr  (mem_addr),
        .sr_rdata  (sr_rdata),
        .mem_wr_ok (mem_wr_ok),
        .sr_wr_ok  (sr_wr_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_prot(input logic [1:0] bp, input logic [12:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 13'h1800;
            2'b10:   return a >= 13'h1000;
            default: return 1'b1;
        endcase
    endfunction

    task automatic strobe(input logic s, input logic c, input logic w, input logic [7:0] d);
        @(negedge clk);
        wel_set = s; wel_clr = c; sr_wr = w; sr_wdata = d;
        @(negedge clk);
        wel_set = 0; wel_clr = 0; sr_wr = 0; sr_wdata = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    task automatic program_sr(input logic [7:0] d);
        strobe(1, 0, 0, 8'h00);
        strobe(0, 1, 1, d);
    endtask

    task automatic t_reset();
        check("R2 reset latch", sr_rdata, 8'h00);
        check("R2 reset mem grant", mem_wr_ok, 0);
        check("R2 reset sr grant", sr_wr_ok, 0);
    endtask

    task automatic t_latch();
        strobe(1, 0, 0, 8'h00);
        check("R2 set", sr_rdata, 8'h02);
        check("R1 layout latch bit", sr_rdata[1], 1);
        strobe(0, 1, 0, 8'h00);
        check("R2 clear", sr_rdata, 8'h00);
        strobe(1, 0, 0, 8'h00);
        strobe(1, 1, 0, 8'h00);
        check("R2 clear wins", sr_rdata, 8'h00);
    endtask

    task automatic t_locked_write();
        strobe(0, 0, 1, 8'hFF);
        check("R6 locked status write ignored", sr_rdata, 8'h00);
    endtask

    task automatic t_same_edge();
        strobe(1, 0, 0, 8'h00);
        strobe(0, 1, 1, 8'hFF);
        check("R10 write plus clear", sr_rdata, 8'h8C);
        check("R1 fixed zeros", {sr_rdata[6:4], sr_rdata[0]}, 4'h0);
        strobe(1, 0, 0, 8'h00);
        strobe(0, 0, 1, 8'h00);
        check("R9 write zeros keep latch", sr_rdata, 8'h02);
        strobe(0, 0, 1, 8'h84);
        check("R9 only protect bits loaded", sr_rdata, 8'h86);
        strobe(0, 0, 1, 8'h08);
        check("R3 latch unchanged by write", sr_rdata, 8'h0A);
        strobe(0, 1, 0, 8'h00);
        strobe(0, 0, 0, 8'h00);
        check("R3 write cannot set latch", sr_rdata[1], 0);
        program_sr(8'h00);
    endtask

    task automatic t_ranges();
        logic [12:0] pts [6] = '{13'h0000, 13'h0FFF, 13'h1000, 13'h17FF, 13'h1800, 13'h1FFF};
        for (int b = 0; b < 4; b++) begin
            program_sr({4'h0, b[1:0], 2'b00});
            strobe(1, 0, 0, 8'h00);
            for (int i = 0; i < 6; i++) begin
                for (int p = 0; p < 2; p++) begin
                    @(negedge clk);
                    mem_addr = pts[i]; wp_n = p[0];
                    #1;
                    check(p ? "R4 range grant" : "R5 pin ignored for array",
                          mem_wr_ok, !exp_prot(b[1:0], pts[i]));
                end
            end
            strobe(0, 1, 0, 8'h00);
            #1 check("R4 no grant without latch", mem_wr_ok, 0);
        end
        wp_n = 1;
        program_sr(8'h00);
    endtask

    task automatic t_pin();
        program_sr(8'h80);
        strobe(1, 0, 0, 8'h00);
        @(negedge clk); wp_n = 0; #1;
        check("R6 pin blocks", sr_wr_ok, 0);
        strobe(0, 0, 1, 8'h0C);
        check("R6 blocked write no change", sr_rdata, 8'h82);
        @(negedge clk); wp_n = 1; #1;
        check("R6 pin released", sr_wr_ok, 1);
        strobe(0, 0, 1, 8'h00);
        @(negedge clk); wp_n = 0; #1;
        check("R7 enable off ignores pin", sr_wr_ok, 1);
        strobe(0, 0, 1, 8'h0C);
        check("R7 write with pin low", sr_rdata, 8'h0E);
        wp_n = 1;
        strobe(0, 1, 0, 8'h00);
    endtask

    task automatic t_reset_keep();
        program_sr(8'h88);
        strobe(1, 0, 0, 8'h00);
        do_reset();
        check("R8 protect bits kept", sr_rdata, 8'h88);
        program_sr(8'h00);
    endtask

    task automatic t_stream();
        logic [12:0] a = 13'h17FD;
        program_sr(8'h04);
        strobe(1, 0, 0, 8'h00);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); mem_addr = a; #1;
            check("R11 streaming boundary", mem_wr_ok, (a < 13'h1800));
            a = a + 1;
        end
        @(negedge clk); mem_addr = 13'h1FFF; #1;
        check("R11 top address", mem_wr_ok, 0);
        @(negedge clk); mem_addr = 13'h0000; #1;
        check("R11 wrapped address", mem_wr_ok, 1);
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_latch();
        t_locked_write();
        t_same_edge();
        t_ranges();
        t_pin();
        t_reset_keep();
        t_stream();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule